// File: doc/BRIEF.md
# FPGA Configuration Bridge Register Block

This block sits on an 8-bit synchronous local bus and drives the byte-wide configuration port of a target FPGA. Software writes a mode register and a flash page register. Software then streams configuration bytes into a write-only data register. Each accepted byte appears on the configuration port, either in natural bit order or bit-reversed, with a one-cycle chip-select/write pulse. Once the target raises its done indication, further data writes are dropped and never reach the port.

The flash page register extends the bus offset into a full flash address, because pages are fixed at 2 MB. The block also turns a raw event line into an interrupt. In edge mode a rising edge is latched until software clears it. In level mode the event line is passed straight through.

Top module: `cfgbr_top`

## Requirements
- R1: After a synchronous active-high reset, the mode and page registers read 0, `irq_out` is low while `evt_in` is low, `cfg_strobe` is 0, `cfg_cs_n` and `cfg_wr_n` are 1, and `cfg_data` is 0.
- R2: A bus write to address 0 stores bit 0 as the reverse-order select and bit 7 as the interrupt-style select (0 edge, 1 level). A read of address 0 returns those two bits in the same positions, with bits 6 to 1 reading 0.
- R3: A bus write to address 1 stores all 8 bits of the page register, and a read of address 1 returns them. The register holds its value when it is not written.
- R4: `flash_addr` equals the page register in bits 28 to 21 concatenated with `lb_offset` in bits 20 to 0, combinationally.
- R5: A write to address 2 while `cfg_done` is low, with reverse-order select 0, makes `cfg_data[i]` equal written bit i in the next cycle. In that same cycle `cfg_strobe` is 1 and `cfg_cs_n` and `cfg_wr_n` are 0. All three return to idle the cycle after, unless another write is accepted.
- R6: With reverse-order select 1, an accepted write makes `cfg_data[i]` equal written bit 7-i. The select value used is the one held before the write.
- R7: A write to address 2 while `cfg_done` is high produces no strobe or pulse, and `cfg_data` keeps its previous value.
- R8: Reads of addresses 2 and 3 return 0. A write to address 3 changes no register.
- R9: In edge mode, a cycle where `evt_in` is high after being low in the previous cycle sets a pending flag. `irq_out` is high from the next cycle on, even if `evt_in` falls, until it is cleared.
- R10: The pending flag is cleared by a cycle with `irq_clr` high or with a bus write to address 0, so `irq_out` is low in the next cycle. A new rising edge in the same cycle wins over the clear.
- R11: In level mode, `irq_out` follows `evt_in` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write qualifier for the current cycle |
| bus_addr | input | 2 | Register select (0 mode, 1 page, 2 config data, 3 unused) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| lb_offset | input | 21 | Low flash address bits from the bus |
| flash_addr | output | 29 | Full flash address |
| cfg_done | input | 1 | Target reports configuration complete |
| cfg_data | output | 8 | Configuration data byte |
| cfg_cs_n | output | 1 | Active-low chip select, one cycle per accepted byte |
| cfg_wr_n | output | 1 | Active-low write, one cycle per accepted byte |
| cfg_strobe | output | 1 | Active-high write strobe, one cycle per accepted byte |
| evt_in | input | 1 | Raw interrupt event |
| irq_clr | input | 1 | Clears a pending edge interrupt |
| irq_out | output | 1 | Interrupt output |

## Verification
A wrong reverse-order select shows up on `cfg_data` in the cycle after the first accepted byte whose pattern is not a palindrome. A wrong page value shows up immediately on `flash_addr` and on the address-1 readback. A stuck or lost pending flag is exposed within one cycle of the event edge or the clear. A done gate that leaks is seen as an unexpected strobe one cycle after the blocked write. Because `cfg_data` only changes on accepted writes, any corruption persists and is caught at every later comparison.

// File: rtl/cfgbr_pkg.sv
package cfgbr_pkg;

    parameter int DATA_W   = 8;
    parameter int PAGE_W   = 8;
    parameter int OFS_W    = 21;
    parameter int SEL_W    = 2;
    localparam int FADDR_W = PAGE_W + OFS_W;

    localparam int BIT_REV   = 0;
    localparam int BIT_LEVEL = 7;

    typedef enum logic [SEL_W-1:0] {
        SEL_MODE = 2'd0,
        SEL_PAGE = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic level;
        logic rev;
    } mode_t;

    typedef struct packed {
        logic mode_we;
        logic page_we;
        logic data_we;
    } wr_en_t;

    function automatic logic [DATA_W-1:0] order_byte(input logic [DATA_W-1:0] b,
                                                     input logic rev);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++) r[i] = b[DATA_W-1-i];
        return rev ? r : b;
    endfunction

endpackage

// File: rtl/cfgbr_decode.sv
module cfgbr_decode
    import cfgbr_pkg::*;
(
    input  logic             bus_wr,
    input  logic [SEL_W-1:0] bus_addr,
    output wr_en_t           wen
);
    reg_sel_e sel;

    always_comb begin
        sel         = reg_sel_e'(bus_addr);
        wen         = '0;
        wen.mode_we = bus_wr && (sel == SEL_MODE);
        wen.page_we = bus_wr && (sel == SEL_PAGE);
        wen.data_we = bus_wr && (sel == SEL_DATA);
    end

    always_comb begin
        if (bus_wr) begin
            assert_onehot_wen_R8: assert ($onehot0({wen.mode_we, wen.page_we, wen.data_we}));
        end
    end
endmodule

// File: rtl/cfgbr_regs.sv
module cfgbr_regs
    import cfgbr_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int PW  = PAGE_W,
    parameter int OW  = OFS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_en_t           wen,
    input  logic [SEL_W-1:0] bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    input  logic [OW-1:0]    lb_offset,
    output logic [DW-1:0]    bus_rdata,
    output logic [PW+OW-1:0] flash_addr,
    output mode_t            mode
);
    logic [PW-1:0] page;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '0;
            page <= '0;
        end else begin
            if (wen.mode_we) begin
                mode.rev   <= bus_wdata[BIT_REV];
                mode.level <= bus_wdata[BIT_LEVEL];
            end
            if (wen.page_we) page <= bus_wdata[PW-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (reg_sel_e'(bus_addr))
            SEL_MODE: begin
                bus_rdata[BIT_REV]   = mode.rev;
                bus_rdata[BIT_LEVEL] = mode.level;
            end
            SEL_PAGE: bus_rdata[PW-1:0] = page;
            default:  bus_rdata = '0;
        endcase
    end

    assign flash_addr = {page, lb_offset};

    assert_page_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !wen.page_we |=> $stable(page));

    assert_mode_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !wen.mode_we |=> $stable(mode));
endmodule

// File: rtl/cfgbr_cfg_port.sv
module cfgbr_cfg_port
    import cfgbr_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          data_we,
    input  logic          done,
    input  logic          rev,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cfg_data,
    output logic          cfg_cs_n,
    output logic          cfg_wr_n,
    output logic          cfg_strobe
);
    logic accept;
    assign accept = data_we && !done;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_data   <= '0;
            cfg_cs_n   <= 1'b1;
            cfg_wr_n   <= 1'b1;
            cfg_strobe <= 1'b0;
        end else begin
            cfg_strobe <= accept;
            cfg_cs_n   <= !accept;
            cfg_wr_n   <= !accept;
            if (accept) cfg_data <= order_byte(wdata, rev);
        end
    end

    assert_done_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        (data_we && done) |=> (!cfg_strobe && cfg_cs_n && $stable(cfg_data)));

    assert_accept_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        (data_we && !done) |=> (cfg_strobe && !cfg_cs_n && !cfg_wr_n));

    assert_reverse_ends_R6: assert property (@(posedge clk) disable iff (rst)
        (data_we && !done && rev) |=>
        (cfg_data[0] == $past(wdata[DW-1]) && cfg_data[DW-1] == $past(wdata[0])));
endmodule

// File: rtl/cfgbr_irq.sv
module cfgbr_irq (
    input  logic clk,
    input  logic rst,
    input  logic level,
    input  logic evt_in,
    input  logic irq_clr,
    input  logic mode_wr,
    output logic irq_out
);
    logic evt_q;
    logic pending;
    logic rise;

    assign rise = evt_in && !evt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q   <= 1'b0;
            pending <= 1'b0;
        end else begin
            evt_q <= evt_in;
            if (rise && !level)            pending <= 1'b1;
            else if (irq_clr || mode_wr)   pending <= 1'b0;
        end
    end

    assign irq_out = level ? evt_in : pending;

    assert_edge_sets_R9: assert property (@(posedge clk) disable iff (rst)
        (rise && !level && !mode_wr) |=> irq_out);

    assert_clear_drops_R10: assert property (@(posedge clk) disable iff (rst)
        (irq_clr && !mode_wr && !rise && !level) |=> !irq_out);
endmodule

// File: rtl/cfgbr_top.sv
module cfgbr_top
    import cfgbr_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int PW = PAGE_W,
    parameter int OW = OFS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [SEL_W-1:0] bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [OW-1:0]    lb_offset,
    output logic [PW+OW-1:0] flash_addr,
    input  logic             cfg_done,
    output logic [DW-1:0]    cfg_data,
    output logic             cfg_cs_n,
    output logic             cfg_wr_n,
    output logic             cfg_strobe,
    input  logic             evt_in,
    input  logic             irq_clr,
    output logic             irq_out
);
    wr_en_t wen;
    mode_t  mode;

    cfgbr_decode u_dec (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .wen      (wen)
    );

    cfgbr_regs #(.DW(DW), .PW(PW), .OW(OW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wen        (wen),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .lb_offset  (lb_offset),
        .bus_rdata  (bus_rdata),
        .flash_addr (flash_addr),
        .mode       (mode)
    );

    cfgbr_cfg_port #(.DW(DW)) u_port (
        .clk        (clk),
        .rst        (rst),
        .data_we    (wen.data_we),
        .done       (cfg_done),
        .rev        (mode.rev),
        .wdata      (bus_wdata),
        .cfg_data   (cfg_data),
        .cfg_cs_n   (cfg_cs_n),
        .cfg_wr_n   (cfg_wr_n),
        .cfg_strobe (cfg_strobe)
    );

    cfgbr_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .level   (mode.level),
        .evt_in  (evt_in),
        .irq_clr (irq_clr),
        .mode_wr (wen.mode_we),
        .irq_out (irq_out)
    );
endmodule

// File: tb/tb_cfgbr_top.sv
module tb_cfgbr_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [1:0]  bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic [20:0] lb_offset;
    logic [28:0] flash_addr;
    logic        cfg_done;
    logic [7:0]  cfg_data;
    logic        cfg_cs_n, cfg_wr_n, cfg_strobe;
    logic        evt_in, irq_clr, irq_out;

    int n_checks = 0;
    int n_fail   = 0;

    // bench model
    logic       m_rev, m_level, m_pend, m_evt_prev, m_strobe;
    logic [7:0] m_page, m_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgbr_top dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lb_offset(lb_offset),
        .flash_addr(flash_addr), .cfg_done(cfg_done), .cfg_data(cfg_data),
        .cfg_cs_n(cfg_cs_n), .cfg_wr_n(cfg_wr_n), .cfg_strobe(cfg_strobe),
        .evt_in(evt_in), .irq_clr(irq_clr), .irq_out(irq_out)
    );

    function automatic logic [7:0] flip(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[7-i] = b[i];
        return r;
    endfunction

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return {m_level, 6'b0, m_rev};
            2'd1:    return m_page;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // called at negedge: check registered outputs, drive, check comb outputs, advance
    task automatic step(input logic wr, input logic [1:0] a, input logic [7:0] d,
                        input logic done, input logic evt, input logic clr,
                        input logic [20:0] ofs);
        logic rise;
        chk(m_strobe ? "R5 strobe" : "R7 strobe", {29'b0, cfg_strobe, cfg_cs_n, cfg_wr_n},
            {29'b0, m_strobe, !m_strobe, !m_strobe});
        chk(m_rev ? "R6 data" : "R5/R7 data", {24'b0, cfg_data}, {24'b0, m_data});
        bus_wr = wr; bus_addr = a; bus_wdata = d; cfg_done = done;
        evt_in = evt; irq_clr = clr; lb_offset = ofs;
        #1;
        chk(a == 2'd0 ? "R2 read" : (a == 2'd1 ? "R3 read" : "R8 read"),
            {24'b0, bus_rdata}, {24'b0, exp_read(a)});
        chk("R4 flash", {3'b0, flash_addr}, {3'b0, m_page, ofs});
        chk(m_level ? "R11 irq" : "R9/R10 irq", {31'b0, irq_out},
            {31'b0, m_level ? evt : m_pend});
        @(posedge clk);
        rise = evt && !m_evt_prev;
        m_evt_prev = evt;
        m_strobe = wr && a == 2'd2 && !done;
        if (m_strobe) m_data = m_rev ? flip(d) : d;
        if (rise && !m_level)               m_pend = 1'b1;
        else if (clr || (wr && a == 2'd0))  m_pend = 1'b0;
        if (wr && a == 2'd0) begin m_rev = d[0]; m_level = d[7]; end
        if (wr && a == 2'd1) m_page = d;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int seed = 32'h5eed_c0de;
        logic evt_r;
        void'($urandom(seed));
        rst = 1; bus_wr = 0; bus_addr = 0; bus_wdata = 0; cfg_done = 0;
        evt_in = 0; irq_clr = 0; lb_offset = 0;
        m_rev = 0; m_level = 0; m_pend = 0; m_evt_prev = 0; m_strobe = 0;
        m_page = 0; m_data = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 cfg idle", {22'b0, cfg_data, cfg_strobe, cfg_cs_n}, {22'b0, 8'h00, 1'b0, 1'b1});
        chk("R1 irq", {31'b0, irq_out}, 32'd0);
        #1;
        chk("R1 mode", {24'b0, bus_rdata}, 32'd0);
        @(negedge clk);

        // directed: natural order, then reversed, then done-blocked
        step(1, 2'd2, 8'h1E, 0, 0, 0, 21'h0);
        step(0, 2'd0, 8'h00, 0, 0, 0, 21'h1FFFFF);
        step(1, 2'd0, 8'h81, 0, 0, 0, 21'h0);        // rev + level
        step(1, 2'd2, 8'h1E, 0, 0, 0, 21'h0);
        step(1, 2'd2, 8'hC4, 1, 0, 0, 21'h0);        // blocked, R7
        step(1, 2'd3, 8'hFF, 0, 0, 0, 21'h0);        // R8 no effect
        step(0, 2'd0, 8'h00, 0, 1, 0, 21'h0);        // R11 follows
        step(1, 2'd0, 8'h00, 0, 0, 0, 21'h0);        // back to edge, natural
        step(1, 2'd1, 8'hA5, 0, 1, 0, 21'h12345);    // rise sets pending, R9
        step(0, 2'd1, 8'h00, 0, 0, 0, 21'h0);        // evt falls, still pending
        step(0, 2'd1, 8'h00, 0, 1, 1, 21'h0);        // clear with rise: rise wins
        step(0, 2'd1, 8'h00, 0, 1, 1, 21'h0);        // clear, no rise, R10
        step(0, 2'd3, 8'h00, 0, 0, 0, 21'h0);

        // constrained random
        evt_r = 0;
        for (int k = 0; k < 4000; k++) begin
            logic [1:0] a;
            logic [7:0] d;
            a = 2'($urandom_range(0, 3));
            d = 8'($urandom);
            if (a == 2'd0) d = d & 8'h81;
            if ($urandom_range(0, 5) == 0) evt_r = !evt_r;
            step(($urandom_range(0, 3) != 0), a, d, ($urandom_range(0, 3) == 0),
                 evt_r, ($urandom_range(0, 15) == 0), 21'($urandom));
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule